// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block sits on the host side of an in-system programming link. It brings a target device into its serial programming mode. On a start request it holds the target's reset line low for a settling time. It then sends the four-byte enable frame 0xAC, 0x53, 0x00, 0x00 through a byte-level SPI master, which is reached through a request/acknowledge handshake. The byte that the master receives while the third frame byte is shifted out decides the outcome. If that byte equals 0x53, the link is in step and the sequencer reports done.

On a mismatch the sequencer does not cut the frame short. The fourth byte is always sent. The sequencer then raises the target reset for a fixed pulse, waits out the settling time again, and sends a fresh enable frame. A parameterised attempt limit bounds this loop. When the limit is used up, the block stops in an error state. All delays are cycle counts, so short values can be used in simulation.

The SPI master itself is outside the block. The block assumes that the master keeps SCK low whenever no transfer is in progress.

Top module: `prog_entry_seq`

## Requirements
- R1: After reset, tgt_reset_o, xfer_req_o, busy_o, done_o and error_o are all 0.
- R2: After start_i is accepted, tgt_reset_o stays 0 and no transfer is requested for exactly PWRUP_CYC cycles, and then the first frame byte is requested.
- R3: Each frame carries the bytes 0xAC, 0x53, 0x00, 0x00 in that order. Each byte is held on xfer_tx_o, with xfer_req_o high, until the cycle in which xfer_ack_i is 1.
- R4: All four bytes of a frame are transferred, whether or not the echo matched.
- R5: If xfer_rx_i equals 0x53 when the third byte is acknowledged, done_o rises, busy_o falls, and no further reset pulse or transfer occurs.
- R6: After a mismatched echo, tgt_reset_o is 1 for exactly RST_PULSE_CYC cycles. It is then 0 for exactly PWRUP_CYC cycles before the next frame starts, and no transfer is requested while it is 1.
- R7: After MAX_TRIES frames with a mismatched echo, error_o rises, busy_o falls, and no further pulses or transfers occur.
- R8: A start_i pulse while busy_o is 1 has no effect, so the number of frames and pulses is unchanged.
- R9: A start_i pulse in the done or error state begins a new sequence and clears done_o and error_o.
- R10: The bytes received during the first, second and fourth transfers do not affect the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to start the entry sequence |
| xfer_req_o | output | 1 | Byte transfer request to the SPI master |
| xfer_tx_o | output | 8 | Byte to transmit |
| xfer_ack_i | input | 1 | One-cycle completion strobe from the SPI master |
| xfer_rx_i | input | 8 | Byte received, valid with xfer_ack_i |
| tgt_reset_o | output | 1 | Target reset line, active high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Target entered programming mode |
| error_o | output | 1 | Attempt limit exhausted |

## Verification
The assertions assume that the SPI master pulses xfer_ack_i for one cycle, and only while xfer_req_o is high. They also assume that xfer_rx_i is valid in that same cycle. The bench master keeps to this contract. It waits at least one falling edge after seeing a request, raises the acknowledge for a single cycle, and varies its latency per byte from zero to two cycles. A sweep runs every failure count from none up to the attempt limit. Each run also injects a second start while busy, and the non-echo bytes return 0x53 so that a wrong decode would show up.

// File: rtl/prog_entry_pkg.sv
package prog_entry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HOLD,
      ST_PULSE,
      ST_WAIT,
      ST_SEND,
      ST_DONE,
      ST_FAIL
   } seq_state_e;

   localparam int unsigned FRAME_LEN = 4;
   localparam int unsigned ECHO_POS  = 2;
   localparam logic [7:0]  SYNC_BYTE = 8'h53;

   function automatic logic [7:0] frame_byte(input logic [1:0] idx);
      case (idx)
         2'd0:    frame_byte = 8'hAC;
         2'd1:    frame_byte = SYNC_BYTE;
         default: frame_byte = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/prog_cycle_timer.sv
module prog_cycle_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         expire_o
);

   generate
      if (W < 1) begin : g_bad_width
         $error("prog_cycle_timer: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= load_val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = (cnt_q == '0);

   // count only ever moves down by one unless reloaded
   p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/prog_enable_frame.sv
module prog_enable_frame
   import prog_entry_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_i,
   input  logic       ack_i,
   input  logic [7:0] rx_i,
   output logic       req_o,
   output logic [7:0] tx_o,
   output logic       fin_o,
   output logic       echo_ok_o
);

   generate
      if (ECHO_POS >= FRAME_LEN - 1) begin : g_bad_pos
         $error("prog_enable_frame: echo must be judged before the last byte");
      end
   endgenerate

   logic       active_q;
   logic [1:0] idx_q;
   logic       echo_q;
   logic       last_ack;

   assign last_ack = active_q && ack_i && (idx_q == 2'(FRAME_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         echo_q   <= 1'b0;
      end else if (go_i && !active_q) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         echo_q   <= 1'b0;
      end else if (active_q && ack_i) begin
         if (idx_q == 2'(ECHO_POS)) echo_q <= (rx_i == SYNC_BYTE);
         if (last_ack) begin
            active_q <= 1'b0;
            idx_q    <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign req_o     = active_q;
   assign tx_o      = frame_byte(idx_q);
   assign fin_o     = last_ack;
   assign echo_ok_o = echo_q;

   p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> (req_o && $stable(tx_o)));

   p_fin_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |-> (ack_i && req_o));

   p_first_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> (tx_o == 8'hAC));

endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq
   import prog_entry_pkg::*;
#(
   parameter int unsigned PWRUP_CYC     = 16,
   parameter int unsigned RST_PULSE_CYC = 4,
   parameter int unsigned MAX_TRIES     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   output logic       xfer_req_o,
   output logic [7:0] xfer_tx_o,
   input  logic       xfer_ack_i,
   input  logic [7:0] xfer_rx_i,
   output logic       tgt_reset_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       error_o
);

   localparam int unsigned LONGEST = (PWRUP_CYC > RST_PULSE_CYC) ? PWRUP_CYC : RST_PULSE_CYC;
   localparam int unsigned TW      = (LONGEST < 2) ? 1 : $clog2(LONGEST);
   localparam int unsigned RW      = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES);

   generate
      if (PWRUP_CYC < 1) begin : g_bad_pwrup
         $error("prog_entry_seq: PWRUP_CYC must be at least 1");
      end
      if (RST_PULSE_CYC < 1) begin : g_bad_pulse
         $error("prog_entry_seq: RST_PULSE_CYC must be at least 1");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("prog_entry_seq: MAX_TRIES must be at least 1");
      end
   endgenerate

   seq_state_e    state_q, state_d;
   logic [RW-1:0] tries_q;
   logic          tries_inc, tries_clr;
   logic          tmr_load, tmr_exp;
   logic [TW-1:0] tmr_val;
   logic          frame_go, frame_fin, frame_ok;

   prog_cycle_timer #(.W(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expire_o   (tmr_exp)
   );

   prog_enable_frame u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (frame_go),
      .ack_i     (xfer_ack_i),
      .rx_i      (xfer_rx_i),
      .req_o     (xfer_req_o),
      .tx_o      (xfer_tx_o),
      .fin_o     (frame_fin),
      .echo_ok_o (frame_ok)
   );

   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = TW'(PWRUP_CYC - 1);
      frame_go  = 1'b0;
      tries_inc = 1'b0;
      tries_clr = 1'b0;
      case (state_q)
         ST_IDLE, ST_DONE, ST_FAIL: begin
            if (start_i) begin
               state_d   = ST_HOLD;
               tmr_load  = 1'b1;
               tries_clr = 1'b1;
            end
         end
         ST_HOLD, ST_WAIT: begin
            if (tmr_exp) begin
               state_d  = ST_SEND;
               frame_go = 1'b1;
            end
         end
         ST_PULSE: begin
            if (tmr_exp) begin
               state_d  = ST_WAIT;
               tmr_load = 1'b1;
            end
         end
         ST_SEND: begin
            if (frame_fin) begin
               if (frame_ok) begin
                  state_d = ST_DONE;
               end else if (tries_q == RW'(MAX_TRIES - 1)) begin
                  state_d = ST_FAIL;
               end else begin
                  state_d   = ST_PULSE;
                  tmr_load  = 1'b1;
                  tmr_val   = TW'(RST_PULSE_CYC - 1);
                  tries_inc = 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tries_q <= '0;
      end else begin
         state_q <= state_d;
         if (tries_clr)      tries_q <= '0;
         else if (tries_inc) tries_q <= tries_q + 1'b1;
      end
   end

   assign tgt_reset_o = (state_q == ST_PULSE);
   assign busy_o      = (state_q == ST_HOLD) || (state_q == ST_PULSE) ||
                        (state_q == ST_WAIT) || (state_q == ST_SEND);
   assign done_o      = (state_q == ST_DONE);
   assign error_o     = (state_q == ST_FAIL);

   p_no_xfer_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_reset_o |-> !xfer_req_o);

   p_reset_fall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tgt_reset_o) |-> (!xfer_req_o && busy_o));

   p_tries_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q < RW'(MAX_TRIES) || MAX_TRIES == (1 << RW));

   p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && !xfer_req_o && !tgt_reset_o));

   p_error_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (error_o && !start_i) |=> (error_o && !xfer_req_o && !tgt_reset_o));

   p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !tgt_reset_o && !xfer_req_o) |=> !done_o && !error_o);

   p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy_o, done_o, error_o}));

endmodule

// File: tb/test_prog_entry_seq.sv
module test_prog_entry_seq;

   localparam int CLK_PERIOD = 10;
   localparam int PW  = 5;
   localparam int RP  = 3;
   localparam int MT  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       xfer_req_o;
   logic [7:0] xfer_tx_o;
   logic       xfer_ack_i = 1'b0;
   logic [7:0] xfer_rx_i = 8'h00;
   logic       tgt_reset_o, busy_o, done_o, error_o;

   int n_chk = 0;
   int n_bad = 0;
   int fail_left = 0;
   int frames = 0;
   int bytes_sent = 0;
   int pulses = 0;
   bit mon_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prog_entry_seq #(.PWRUP_CYC(PW), .RST_PULSE_CYC(RP), .MAX_TRIES(MT)) i_prog_entry_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .xfer_req_o(xfer_req_o), .xfer_tx_o(xfer_tx_o),
      .xfer_ack_i(xfer_ack_i), .xfer_rx_i(xfer_rx_i),
      .tgt_reset_o(tgt_reset_o), .busy_o(busy_o),
      .done_o(done_o), .error_o(error_o));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   function automatic int exp_byte(input int i);
      return (i == 0) ? 32'hAC : (i == 1) ? 32'h53 : 0;
   endfunction

   // SPI master model: acknowledges each request after 0..2 cycles
   initial begin
      int bidx;
      bidx = 0;
      forever begin
         @(negedge clk);
         xfer_ack_i = 1'b0;
         if (mon_on && xfer_req_o) begin
            chk(int'(xfer_tx_o) == exp_byte(bidx), "R3 byte order", int'(xfer_tx_o), exp_byte(bidx));
            for (int w = 0; w < bidx % 3; w++) begin
               @(negedge clk);
               chk(xfer_req_o && int'(xfer_tx_o) == exp_byte(bidx), "R3 byte held", int'(xfer_tx_o), exp_byte(bidx));
            end
            // R10: non-echo positions return the sync value, echo position decides
            xfer_rx_i = (bidx == 2 && fail_left > 0) ? 8'h00 : 8'h53;
            xfer_ack_i = 1'b1;
            bytes_sent++;
            if (bidx == 3) begin
               frames++;
               if (fail_left > 0) fail_left--;
               bidx = 0;
            end else begin
               bidx++;
            end
         end
      end
   end

   // timing monitor for reset pulses and settling gaps
   initial begin
      int gap, run;
      bit prev_req, prev_rst;
      gap = 0; run = 0; prev_req = 0; prev_rst = 0;
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (tgt_reset_o) begin
               run++;
               gap = 0;
               chk(!xfer_req_o, "R6 no transfer in reset", int'(xfer_req_o), 0);
            end else begin
               if (prev_rst) begin
                  chk(run == RP, "R6 pulse width", run, RP);
                  pulses++;
                  run = 0;
               end
               if (busy_o && !xfer_req_o) gap++;
            end
            if (xfer_req_o && !prev_req) begin
               chk(gap == PW, "R2/R6 settle gap", gap, PW);
               gap = 0;
            end
            if (!busy_o) gap = 0;
         end
         prev_req = xfer_req_o;
         prev_rst = tgt_reset_o;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      summary();
   end

   task automatic run_seq(input int nf);
      int exp_frames;
      int lim;
      fail_left = nf;
      frames = 0; bytes_sent = 0; pulses = 0;
      exp_frames = (nf < MT) ? nf + 1 : MT;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(busy_o && !done_o && !error_o, "R9 restart clears flags", int'({busy_o, done_o, error_o}), 4);
      @(negedge clk); start_i = 1'b1;      // R8: ignored while busy
      @(negedge clk); start_i = 1'b0;
      lim = 0;
      while (busy_o && lim < 5000) begin @(negedge clk); lim++; end
      chk(frames == exp_frames, "R8 frame count", frames, exp_frames);
      chk(bytes_sent == 4 * exp_frames, "R4 full frames", bytes_sent, 4 * exp_frames);
      chk(pulses == exp_frames - 1, "R6 pulse count", pulses, exp_frames - 1);
      if (nf < MT) chk(done_o && !error_o, "R5 done after match", int'(done_o), 1);
      else         chk(error_o && !done_o, "R7 error after limit", int'(error_o), 1);
      repeat (12) begin
         @(negedge clk);
         chk(!xfer_req_o && !tgt_reset_o && !busy_o, "R5/R7 quiet after end",
             int'({xfer_req_o, tgt_reset_o, busy_o}), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!tgt_reset_o && !xfer_req_o && !busy_o && !done_o && !error_o, "R1 reset state",
          int'({tgt_reset_o, xfer_req_o, busy_o, done_o, error_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!tgt_reset_o && !xfer_req_o && !busy_o && !done_o && !error_o, "R1 after release",
          int'({tgt_reset_o, xfer_req_o, busy_o, done_o, error_o}), 0);
      mon_on = 1'b1;
      for (int nf = 0; nf <= MT; nf++) run_seq(nf);
      for (int nf = MT; nf >= 0; nf--) run_seq(nf);
      summary();
   end

endmodule